// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a clocked single-port memory of parameterised depth. Each word is 36 bits wide, split into four 9-bit lanes, and the block behaves like a cache-style synchronous burst SRAM. Address, write data, the three chip selects, both address-load strobes, the burst-advance input and every write control are sampled on the rising clock edge. A new address can be loaded on any edge, which gives one access per cycle.

An access is started by one of two load strobes. The CPU-side strobe always begins with a read. The controller-side strobe takes the write controls into account. After a load, a 4-beat burst walks the two low address bits in linear or interleaved order while the advance input is low. When the advance input is high the current address is repeated. A static select picks the read output: flow-through, where data is valid in the cycle after the command edge, or registered, where data is valid one cycle later. Output enable and the sleep input act on the output without waiting for a clock. Sleep also makes the core ignore commands while it keeps the array and the burst position.

Top module: `sync_burst_sram`

## Requirements
- R1: A load strobe starts an access only when sel1_n=0, sel2=1 and sel3_n=0. Otherwise the edge is a deselect: it ends any burst, writes nothing and starts no read. Later advance edges are then idle until the next selected load.
- R2: With pipe_sel=0, read data for a read command taken at edge N is on rdata with rdata_vld=1 from just after edge N until edge N+1.
- R3: With pipe_sel=1, the same data appears one cycle later, from just after edge N+1 until edge N+2.
- R4: For a write access with wr_all_n=1 and wr_lane_en_n=0, lane i (wdata bits 9i+8:9i) is stored exactly when wr_lane_n[i]=0. The other lanes of the word keep their contents.
- R5: For a write access with wr_all_n=0, all four lanes are stored whatever wr_lane_en_n and wr_lane_n are.
- R6: An access is a read when wr_all_n=1 and either wr_lane_en_n=1 or wr_lane_n is all ones. Such an access changes no memory word.
- R7: A load with cpu_ld_n=0 is always a read and ignores the write controls. This also holds when ctl_ld_n=0 in the same cycle.
- R8: With lin_order_n=0, the k-th beat (k=0..3) after a load uses address bits [1:0] = (start + k) mod 4. The upper bits stay those of the load.
- R9: With lin_order_n=1, the k-th beat uses address bits [1:0] = start XOR k.
- R10: An edge inside a burst with no load strobe and burst_next_n=1 accesses the same address as the previous access. The write controls apply to it.
- R11: After reset and after a deselect or idle edge, rdata_vld is 0. It drops in the cycle after the edge with pipe_sel=0, and one cycle later with pipe_sel=1.
- R12: While out_en_n=1 or sleep=1, rdata_vld=0 and rdata=0, with no clock needed. Whenever rdata_vld=0, rdata=0.
- R13: An edge with sleep=1 performs no access, writes nothing and leaves the burst position unchanged. The burst resumes from that position once sleep returns to 0.
- R14: Loads on consecutive edges each yield one read result per cycle, in order, with no gap cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, used on load edges |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Read data, zero when not valid |
| rdata_vld | output | 1 | Read data is valid |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| cpu_ld_n | input | 1 | CPU-side load strobe, active low, read-only start |
| ctl_ld_n | input | 1 | Controller-side load strobe, active low |
| burst_next_n | input | 1 | Advance to next burst beat, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Enable per-lane writes, active low |
| wr_lane_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep: ignore commands, blank output |
| pipe_sel | input | 1 | 1 = registered read output, 0 = flow-through |
| lin_order_n | input | 1 | 0 = linear burst order, 1 = interleaved |

## Verification
The hardest overlap is a command edge that lands while an earlier read is still inside the output register in registered mode. A write, a deselect or a sleep edge is accepted in the same cycle that the previous read result is shown. The bench provokes this with loads and burst beats on back-to-back edges, deselects straight after reads, and sleep or output-enable pulses in the middle of bursts, in both output modes. A queue-free behavioural model holds an array copy and two delayed result slots. It judges rdata and rdata_vld after every edge, so a result that is dropped, shifted by one cycle or overwritten shows up as a mismatch.

// File: rtl/sbs_pkg.sv
// Shared types for the synchronous burst SRAM core.
// Assumes a 4-beat burst, so the burst offset is two bits.
package sbs_pkg;

    localparam int BURST_W = 2;

    // Command decoded from the control inputs at one clock edge
    typedef enum logic [2:0] {
        C_IDLE  = 3'd0,
        C_SLEEP = 3'd1,
        C_DESEL = 3'd2,
        C_LOADP = 3'd3,
        C_LOADC = 3'd4,
        C_STEP  = 3'd5,
        C_HOLD  = 3'd6
    } cmd_t;

    function automatic logic is_load(cmd_t c);
        return (c == C_LOADP) || (c == C_LOADC);
    endfunction

    function automatic logic is_access(cmd_t c);
        return (c == C_LOADP) || (c == C_LOADC) || (c == C_STEP) || (c == C_HOLD);
    endfunction

endpackage

// File: rtl/sbs_cmd_decode.sv
// Command decoder: turns the sampled control pins into one command per edge,
// a per-lane write mask and a read request.
// Assumes the burst-active flag comes from the top-level register.
module sbs_cmd_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel1_n,
    input  logic             sel2,
    input  logic             sel3_n,
    input  logic             cpu_ld_n,
    input  logic             ctl_ld_n,
    input  logic             burst_next_n,
    input  logic             sleep,
    input  logic             burst_on,
    input  logic             wr_all_n,
    input  logic             wr_lane_en_n,
    input  logic [LANES-1:0] wr_lane_n,
    output cmd_t             cmd,
    output logic [LANES-1:0] wr_mask,
    output logic             rd_req
);

    logic             selected;
    logic [LANES-1:0] req_mask;
    logic             may_write;

    assign selected = !sel1_n && sel2 && !sel3_n;

    // Pick the command: sleep first, then load strobes, then burst beats
    always_comb begin
        if (sleep)
            cmd = C_SLEEP;
        else if (!cpu_ld_n || !ctl_ld_n) begin
            if (!selected)
                cmd = C_DESEL;
            else if (!cpu_ld_n)
                cmd = C_LOADP;
            else
                cmd = C_LOADC;
        end else if (burst_on)
            cmd = burst_next_n ? C_HOLD : C_STEP;
        else
            cmd = C_IDLE;
    end

    // Lane mask requested by the write pins; the global write overrides lane selects
    always_comb begin
        if (!wr_all_n)
            req_mask = '1;
        else if (!wr_lane_en_n)
            req_mask = ~wr_lane_n;
        else
            req_mask = '0;
    end

    // Writes are allowed on controller loads and burst beats only
    assign may_write = (cmd == C_LOADC) || (cmd == C_STEP) || (cmd == C_HOLD);

    // Final mask and read request
    always_comb begin
        wr_mask = may_write ? req_mask : '0;
        rd_req  = is_access(cmd) && (wr_mask == '0);
    end

endmodule

// File: rtl/sbs_burst_ctr.sv
// Burst address generator for a 4-beat burst. It keeps the start offset and
// the beat count and gives the low address bits for the current edge.
// Assumes load and step are never high together.
module sbs_burst_ctr #(
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CTR_W-1:0] start_lo,
    input  logic             lin_order_n,
    output logic [CTR_W-1:0] lo
);

    logic [CTR_W-1:0] start_q;
    logic [CTR_W-1:0] cnt_q;
    logic [CTR_W-1:0] cnt_use;

    // Hold start offset and beat count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            start_q <= start_lo;
            cnt_q   <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Offset for this edge: next beat when stepping, else the current one
    always_comb begin
        cnt_use = step ? cnt_q + 1'b1 : cnt_q;
        lo      = lin_order_n ? (start_q ^ cnt_use) : (start_q + cnt_use);
    end

    // R8: consecutive linear steps advance the offset by one
    p_linear_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lin_order_n && $past(!lin_order_n) && step && $past(step) && $past(rst_n))
        |-> (lo == $past(lo) + 1'b1));

    // R9: the first interleaved step after a load flips offset bit 0
    p_ileave_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_order_n && step && $past(load) && $past(rst_n))
        |-> (lo == ($past(start_lo) ^ {{(CTR_W-1){1'b0}}, 1'b1})));

endmodule

// File: rtl/sbs_lane_array.sv
// Storage: one memory per lane with its own write enable and a shared
// synchronous read register. A read and a write never share an edge.
module sbs_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANE_W*LANES-1:0]   wdata,
    input  logic [LANES-1:0]          we,
    input  logic                      rd,
    output logic [LANE_W*LANES-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q;

        // Store this lane when its enable is set
        always_ff @(posedge clk) begin
            if (we[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Capture this lane on a read edge
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (rd)
                q <= mem[addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = q;
    end

    // R6: a read edge never writes a lane
    p_rd_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> (we == '0));

endmodule

// File: rtl/sbs_read_path.sv
// Read output stage: tracks the validity of the array's read register and
// adds the optional output register. The output is gated at once by
// output enable and sleep. Assumes pipe_sel changes only while idle.
module sbs_read_path #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_sel,
    input  logic              out_en_n,
    input  logic              sleep,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] arr_q,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);

    logic              v1_q;
    logic              v2_q;
    logic [DATA_W-1:0] d2_q;
    logic              src_v;
    logic [DATA_W-1:0] src_d;

    // First stage: a read was issued at the last edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            v1_q <= 1'b0;
        else
            v1_q <= rd_issue;
    end

    // Output register, used in registered mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2_q <= 1'b0;
            d2_q <= '0;
        end else begin
            v2_q <= v1_q;
            d2_q <= arr_q;
        end
    end

    // Choose the source by mode, then gate it asynchronously
    always_comb begin
        src_v     = pipe_sel ? v2_q : v1_q;
        src_d     = pipe_sel ? d2_q : arr_q;
        rdata_vld = src_v && !out_en_n && !sleep;
        rdata     = rdata_vld ? src_d : '0;
    end

    // R2: flow-through data is valid right after the read edge
    p_flow_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_sel && $past(rd_issue) && $past(rst_n) && !out_en_n && !sleep)
        |-> rdata_vld);

    // R3: registered data is valid one cycle later
    p_pipe_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_sel && $past(pipe_sel) && $past(rd_issue, 2) && $past(rst_n, 2)
         && $past(rst_n) && !out_en_n && !sleep)
        |-> rdata_vld);

endmodule

// File: rtl/sync_burst_sram.sv
// Top of the synchronous burst SRAM core. It decodes the command per edge,
// keeps the burst state, forms the access address and links the array to
// the read output stage. Assumes pipe_sel and lin_order_n are static.
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANE_W*LANES-1:0] wdata,
    output logic [LANE_W*LANES-1:0] rdata,
    output logic                    rdata_vld,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    cpu_ld_n,
    input  logic                    ctl_ld_n,
    input  logic                    burst_next_n,
    input  logic                    wr_all_n,
    input  logic                    wr_lane_en_n,
    input  logic [LANES-1:0]        wr_lane_n,
    input  logic                    out_en_n,
    input  logic                    sleep,
    input  logic                    pipe_sel,
    input  logic                    lin_order_n
);

    localparam int DATA_W = LANE_W * LANES;
    localparam int BASE_W = ADDR_W - BURST_W;

    cmd_t               cmd;
    logic [LANES-1:0]   wr_mask;
    logic               rd_req;
    logic               burst_q;
    logic [BASE_W-1:0]  base_q;
    logic [BURST_W-1:0] ctr_lo;
    logic [ADDR_W-1:0]  eff_addr;
    logic [ADDR_W-1:0]  last_addr_q;
    logic [DATA_W-1:0]  arr_q;
    logic               ld;

    sbs_cmd_decode #(.LANES(LANES)) u_dec (
        .sel1_n       (sel1_n),
        .sel2         (sel2),
        .sel3_n       (sel3_n),
        .cpu_ld_n     (cpu_ld_n),
        .ctl_ld_n     (ctl_ld_n),
        .burst_next_n (burst_next_n),
        .sleep        (sleep),
        .burst_on     (burst_q),
        .wr_all_n     (wr_all_n),
        .wr_lane_en_n (wr_lane_en_n),
        .wr_lane_n    (wr_lane_n),
        .cmd          (cmd),
        .wr_mask      (wr_mask),
        .rd_req       (rd_req)
    );

    assign ld = is_load(cmd);

    sbs_burst_ctr #(.CTR_W(BURST_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (ld),
        .step        (cmd == C_STEP),
        .start_lo    (addr[BURST_W-1:0]),
        .lin_order_n (lin_order_n),
        .lo          (ctr_lo)
    );

    // Burst-active flag and upper address bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
            base_q  <= '0;
        end else if (ld) begin
            burst_q <= 1'b1;
            base_q  <= addr[ADDR_W-1:BURST_W];
        end else if (cmd == C_DESEL) begin
            burst_q <= 1'b0;
        end
    end

    // Access address: the pins on a load, else the burst address
    assign eff_addr = ld ? addr : {base_q, ctr_lo};

    // Remember the last accessed address
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_addr_q <= '0;
        else if (is_access(cmd))
            last_addr_q <= eff_addr;
    end

    sbs_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (eff_addr),
        .wdata (wdata),
        .we    (wr_mask),
        .rd    (rd_req),
        .rdata (arr_q)
    );

    sbs_read_path #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_sel  (pipe_sel),
        .out_en_n  (out_en_n),
        .sleep     (sleep),
        .rd_issue  (rd_req),
        .arr_q     (arr_q),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    // R10: a hold beat reuses the previous address
    p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_HOLD) |-> (eff_addr == last_addr_q));

    // R11: flow-through output drops the cycle after a deselect
    p_desel_flow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_sel && $past(cmd == C_DESEL) && $past(rst_n)) |-> !rdata_vld);

    // R11: registered output drops one cycle later
    p_desel_pipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_sel && $past(pipe_sel) && $past(cmd == C_DESEL, 2)
         && $past(rst_n, 2) && $past(rst_n)) |-> !rdata_vld);

    // R13: sleep leaves the burst state untouched
    p_sleep_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(burst_q) && $stable(base_q)));

    // R7: a CPU-side load never writes
    p_cpu_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ld_n && !sleep) |-> (wr_mask == '0));

endmodule

// File: tb/sync_burst_sram_test.sv
// Bench: a behavioural model of the array and burst state, compared with
// the outputs after every clock edge.
module sync_burst_sram_test;

    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [AW-1:0] addr;
    logic [35:0] wdata;
    logic [35:0] rdata;
    logic        rdata_vld;
    logic        sel1_n, sel2, sel3_n;
    logic        cpu_ld_n, ctl_ld_n, burst_next_n;
    logic        wr_all_n, wr_lane_en_n;
    logic [3:0]  wr_lane_n;
    logic        out_en_n, sleep, pipe_sel, lin_order_n;

    int total = 0;
    int bad = 0;
    string cur_req = "R11";

    always #4 clk = ~clk;

    sync_burst_sram uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_vld(rdata_vld),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .cpu_ld_n(cpu_ld_n), .ctl_ld_n(ctl_ld_n), .burst_next_n(burst_next_n),
        .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .wr_lane_n(wr_lane_n),
        .out_en_n(out_en_n), .sleep(sleep), .pipe_sel(pipe_sel),
        .lin_order_n(lin_order_n)
    );

    // Model state
    logic [35:0] mm [DEPTH];
    bit          m_on;
    int          m_base, m_start, m_k;
    bit          e1v, e2v;
    logic [35:0] e1d, e2d;

    function automatic logic [35:0] pat(int a);
        logic [31:0] t;
        t = 32'(a) * 32'h9E37_79B1;
        return {4'(a), t};
    endfunction

    task automatic model_edge();
        bit nv = 0;
        bit acc = 0;
        bit cpu = 0;
        bit selv;
        int a = 0;
        int mask;
        logic [35:0] nd = e1d;
        if (!rst_n) begin
            m_on = 0; e1v = 0; e2v = 0; e1d = '0; e2d = '0;
            return;
        end
        if (!sleep) begin
            selv = !sel1_n && sel2 && !sel3_n;
            if (!cpu_ld_n || !ctl_ld_n) begin
                if (selv) begin
                    acc = 1; cpu = !cpu_ld_n; a = int'(addr);
                    m_base = a / 4; m_start = a % 4; m_k = 0; m_on = 1;
                end else m_on = 0;
            end else if (m_on) begin
                acc = 1;
                if (!burst_next_n) m_k = (m_k + 1) % 4;
                a = m_base * 4 + (lin_order_n ? (m_start ^ m_k) : ((m_start + m_k) % 4));
            end
            if (acc) begin
                if (cpu) mask = 0;
                else if (!wr_all_n) mask = 15;
                else if (!wr_lane_en_n) mask = int'(~wr_lane_n) & 15;
                else mask = 0;
                if (mask == 0) begin
                    nv = 1; nd = mm[a];
                end else begin
                    for (int l = 0; l < 4; l++)
                        if (mask[l]) mm[a][l*9 +: 9] = wdata[l*9 +: 9];
                end
            end
        end
        e2v = e1v; e2d = e1d;
        e1v = nv; e1d = nd;
    endtask

    task automatic compare();
        bit ev;
        logic [35:0] ed;
        ev = (pipe_sel ? e2v : e1v) && !out_en_n && !sleep;
        ed = ev ? (pipe_sel ? e2d : e1d) : 36'd0;
        total++;
        if (rdata_vld !== ev || rdata !== ed) begin
            bad++;
            $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h",
                     cur_req, rdata_vld, rdata, ev, ed);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #2;
        compare();
        @(negedge clk);
    endtask

    task automatic quiet();
        cpu_ld_n = 1; ctl_ld_n = 1; burst_next_n = 1;
        wr_all_n = 1; wr_lane_en_n = 1; wr_lane_n = 4'hF;
    endtask

    task automatic idle(int n);
        quiet();
        repeat (n) tick();
    endtask

    task automatic ld(bit cpn, bit ctn, int a, bit gn, bit bn, logic [3:0] ln, logic [35:0] d);
        cpu_ld_n = cpn; ctl_ld_n = ctn; burst_next_n = 1;
        addr = AW'(a); wr_all_n = gn; wr_lane_en_n = bn; wr_lane_n = ln; wdata = d;
        tick();
    endtask

    task automatic beat(bit go, bit gn, bit bn, logic [3:0] ln, logic [35:0] d);
        cpu_ld_n = 1; ctl_ld_n = 1; burst_next_n = !go;
        wr_all_n = gn; wr_lane_en_n = bn; wr_lane_n = ln; wdata = d;
        tick();
    endtask

    task automatic rd1(int a);
        ld(0, 1, a, 1, 1, 4'hF, 36'd0);
    endtask

    task automatic burst_read(int a);
        rd1(a);
        repeat (3) beat(1, 1, 1, 4'hF, 36'd0);
        idle(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; addr = '0; wdata = '0;
        sel1_n = 0; sel2 = 1; sel3_n = 0;
        out_en_n = 0; sleep = 0; pipe_sel = 1; lin_order_n = 1;
        quiet();
        @(negedge clk);
        cur_req = "R11";            // reset leaves output invalid
        repeat (3) tick();
        rst_n = 1;

        cur_req = "R5";             // fill by global writes on back-to-back loads
        for (int a = 0; a < DEPTH; a++) ld(1, 0, a, 0, 1, 4'hF, pat(a));
        idle(2);

        cur_req = "R3";             // registered reads, one per edge
        for (int a = 0; a < 12; a++) rd1(a);
        idle(3);
        cur_req = "R14";
        for (int a = 30; a < 40; a++) rd1(a);
        idle(3);

        pipe_sel = 0;
        cur_req = "R2";             // flow-through reads
        for (int a = 50; a < 62; a++) rd1(a);
        idle(2);

        cur_req = "R4";             // every lane mask, then read back
        for (int m = 1; m < 16; m++) begin
            ld(1, 0, 70, 1, 0, ~4'(m), pat(m + 900));
            rd1(70);
        end
        idle(2);

        cur_req = "R6";             // lane enable with no lanes is a read
        ld(1, 0, 71, 1, 0, 4'hF, 36'hF_FFFF_FFFF);
        ld(1, 0, 71, 1, 1, 4'h0, 36'hF_FFFF_FFFF);
        rd1(71);
        idle(2);

        cur_req = "R5";             // global write beats the lane mask
        ld(1, 0, 72, 0, 0, 4'b1110, pat(777));
        ld(1, 0, 73, 0, 1, 4'b0000, pat(778));
        rd1(72); rd1(73);
        idle(2);

        cur_req = "R7";             // CPU load ignores writes, also with both strobes
        ld(0, 1, 74, 0, 0, 4'h0, 36'h1_2345_6789);
        ld(0, 0, 75, 0, 0, 4'h0, 36'h1_2345_6789);
        rd1(74); rd1(75);
        idle(2);

        for (int md = 0; md < 2; md++) begin
            pipe_sel = md[0];
            idle(2);
            cur_req = "R8";         // linear order from each start
            lin_order_n = 0;
            for (int s = 0; s < 4; s++) burst_read(80 + s);
            cur_req = "R9";         // interleaved order from each start
            lin_order_n = 1;
            for (int s = 0; s < 4; s++) burst_read(96 + s);
        end

        cur_req = "R8";             // burst writes then burst read
        lin_order_n = 0;
        ld(1, 0, 113, 0, 1, 4'hF, pat(1113));
        for (int k = 0; k < 3; k++) beat(1, 0, 1, 4'hF, pat(1200 + k));
        idle(1);
        burst_read(112);

        cur_req = "R10";            // hold beats repeat the address, and can write
        lin_order_n = 1;
        rd1(122);
        beat(0, 1, 1, 4'hF, 36'd0);
        beat(1, 1, 1, 4'hF, 36'd0);
        beat(0, 1, 0, 4'b0101, pat(1300));
        beat(0, 1, 1, 4'hF, 36'd0);
        beat(1, 1, 1, 4'hF, 36'd0);
        idle(2);

        cur_req = "R1";             // each select wrong in turn; write must be dropped
        sel1_n = 1; ld(1, 0, 130, 0, 1, 4'hF, 36'd5); beat(1, 0, 1, 4'hF, 36'd6);
        sel1_n = 0; sel2 = 0; ld(0, 1, 131, 1, 1, 4'hF, 36'd0); beat(1, 1, 1, 4'hF, 36'd0);
        sel2 = 1; sel3_n = 1; ld(1, 0, 132, 0, 1, 4'hF, 36'd7);
        sel3_n = 0;
        rd1(130); rd1(131); rd1(132);
        idle(2);

        cur_req = "R11";            // deselect straight after reads, both modes
        for (int md = 0; md < 2; md++) begin
            pipe_sel = md[0];
            idle(2);
            rd1(140); rd1(141);
            sel2 = 0; ld(0, 1, 142, 1, 1, 4'hF, 36'd0); sel2 = 1;
            idle(3);
        end

        cur_req = "R12";            // output enable and sleep blank the output
        for (int md = 0; md < 2; md++) begin
            pipe_sel = md[0];
            rd1(150); out_en_n = 1; rd1(151); rd1(152); out_en_n = 0; rd1(153);
            idle(3);
        end

        cur_req = "R13";            // sleep in mid-burst: ignored, contents and position kept
        pipe_sel = 1; lin_order_n = 0;
        rd1(161);
        beat(1, 1, 1, 4'hF, 36'd0);
        sleep = 1;
        ld(1, 0, 161, 0, 1, 4'hF, 36'd9);
        beat(1, 0, 1, 4'hF, 36'd9);
        sleep = 0;
        beat(1, 1, 1, 4'hF, 36'd0);
        beat(1, 1, 1, 4'hF, 36'd0);
        idle(2);
        burst_read(160);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule